// File: doc/BRIEF.md
# Receive Word Aligner with Bit-Slip

This block sits behind a deserializer and recovers the word boundary in a parallel stream of 8-bit or 10-bit words. The width is fixed at build time by a parameter. Each incoming word may first be inverted. It then enters a two-word window, and one N-bit slice of that window is registered as the aligned output. The slice starts at the current slip offset, where bit 0 of a word is the earliest bit received.

There are two modes. In bit-slip mode, a slip request coming from another clock domain moves the boundary one bit later in the stream. In manual mode, an alignment enable starts a search for a programmable pattern at every offset of the window, and a match moves the boundary onto it. In 8-bit builds, each rising edge of the enable runs one search that ends at the first match. In 10-bit builds, searching goes on for as long as the enable is held high.

Both control requests go through a synchronizer and are taken only if they stay high for two clock cycles. The block reports the current offset and a flag that shows the pattern sitting on the current boundary. In bit-slip mode, the output word can also be emitted bit-reversed.

Top module: `rx_word_aligner`

## Requirements
- R1: While rst_n is low, aligned_word, slip_count and pat_found are all zero.
- R2: Take the window as the current word in the upper N bits and the previous word in the lower N bits. After each clock edge, aligned_word equals bits k through k+N-1 of the window captured at that edge, where k is slip_count.
- R3: In bit-slip mode, a slip request held high for two or more clock cycles raises slip_count by exactly one. Without an accepted request, slip_count does not change.
- R4: slip_count wraps from N-1 back to 0, so N accepted slips return the boundary to where it started.
- R5: A slip request that is high for only one clock cycle is rejected, and slip_count keeps its value.
- R6: In manual mode, slip requests are ignored and slip_count keeps its value.
- R7: While invert_pol is high, every bit of the incoming word is complemented before it enters the window.
- R8: While reverse_bits is high in bit-slip mode, aligned_word bit i carries slice bit N-1-i. In manual mode, reverse_bits has no effect.
- R9: During a search, each offset 0..N-1 of the window is compared with pattern. When one or more offsets match, slip_count takes the lowest of them.
- R10: With N=8, one rising edge of align_en runs a single search that ends at the first match. The offset then holds while align_en stays high, until the next rising edge.
- R11: With N=10, searching continues every cycle while align_en is high and re-locks when the stream shifts. Once align_en is low, the offset holds.
- R12: pat_found is high exactly when the slice registered with aligned_word, taken before any reversal, equals pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Active-low reset |
| rx_word | input | WORD_W | Parallel word from the deserializer, bit 0 earliest |
| mode_manual | input | 1 | 0 = bit-slip mode, 1 = pattern search mode |
| slip_req | input | 1 | Asynchronous slip request, acts on its rising edge |
| align_en | input | 1 | Asynchronous search enable |
| invert_pol | input | 1 | Complement the incoming word |
| reverse_bits | input | 1 | Reverse output bit order (bit-slip mode only) |
| pattern | input | WORD_W | Alignment pattern to search for |
| aligned_word | output | WORD_W | Word on the recovered boundary |
| pat_found | output | 1 | Pattern present on the current boundary |
| slip_count | output | $clog2(WORD_W) | Current slip offset in bits |

## Verification
The bench builds two copies side by side, one with WORD_W=10 and one with WORD_W=8, and drives both with the same controls. Running them together puts the level-sensitive and the edge-sensitive enable behaviours under the same stimulus, so a stream shift made while the enable is still high separates them in one run. The 10-bit copy exercises the count wrap at a width that is not a power of two. The 8-bit copy exercises the wrap at a power of two.

// File: rtl/rxwa_pkg.sv
package rxwa_pkg;

  typedef enum logic {
    WA_MODE_SLIP = 1'b0,
    WA_MODE_HUNT = 1'b1
  } wa_mode_e;

  // Offset step with wrap at the word width.
  function automatic int unsigned wa_wrap_inc(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/rxwa_ctrl_sync.sv
module rxwa_ctrl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic held_lvl,
  output logic rise
);
  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic            held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], async_in};
  end

  // Synchronized level seen on two consecutive cycles.
  assign held_lvl = sh_q[STAGES-1] & sh_q[STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_lvl;
  end

  assign rise = held_lvl & ~held_q;
endmodule

// File: rtl/rxwa_window.sv
module rxwa_window #(
  parameter int WORD_W = 10,
  parameter int CNT_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WORD_W-1:0]     rx_word,
  input  logic                  invert,
  input  logic                  reverse,
  input  logic [WORD_W-1:0]     pattern,
  input  logic [CNT_W-1:0]      offset,
  output logic [2*WORD_W-1:0]   win_o,
  output logic [WORD_W-1:0]     aligned_o,
  output logic                  found_o
);
  localparam int WIN_W = 2 * WORD_W;

  function automatic logic [WORD_W-1:0] flip(input logic [WORD_W-1:0] v);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = v[WORD_W-1-i];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] pick(input logic [WIN_W-1:0] w,
                                             input logic [CNT_W-1:0] k);
    logic [WIN_W-1:0] s;
    s = w >> k;
    return s[WORD_W-1:0];
  endfunction

  logic [WORD_W-1:0] in_pol;
  logic [WORD_W-1:0] old_q;
  logic [WORD_W-1:0] slice;

  assign in_pol = rx_word ^ {WORD_W{invert}};
  assign win_o  = {in_pol, old_q};
  assign slice  = pick(win_o, offset);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_q     <= '0;
      aligned_o <= '0;
      found_o   <= 1'b0;
    end else begin
      old_q     <= in_pol;
      aligned_o <= reverse ? flip(slice) : slice;
      found_o   <= (slice == pattern);
    end
  end
endmodule

// File: rtl/rxwa_search.sv
module rxwa_search #(
  parameter int WORD_W = 10,
  parameter int CNT_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                en_lvl,
  input  logic                en_rise,
  input  logic [2*WORD_W-1:0] win,
  input  logic [WORD_W-1:0]   pattern,
  output logic                hit,
  output logic [CNT_W-1:0]    hit_k
);
  localparam bit LEVEL_EN = (WORD_W != 8);

  logic [WORD_W-1:0] match_vec;
  logic              hunt_q;
  logic              hunting;

  for (genvar k = 0; k < WORD_W; k++) begin : g_cmp
    assign match_vec[k] = (win[k +: WORD_W] == pattern);
  end

  // Lowest matching offset wins.
  always_comb begin
    hit_k = '0;
    for (int k = WORD_W - 1; k >= 0; k--) begin
      if (match_vec[k]) hit_k = CNT_W'(k);
    end
  end

  assign hunting = active & (LEVEL_EN ? en_lvl : (hunt_q | en_rise));
  assign hit     = hunting & (|match_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hunt_q <= 1'b0;
    else        hunt_q <= hunting & ~(|match_vec);
  end
endmodule

// File: rtl/rx_word_aligner.sv
module rx_word_aligner #(
  parameter int WORD_W = 10
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WORD_W-1:0]           rx_word,
  input  logic                        mode_manual,
  input  logic                        slip_req,
  input  logic                        align_en,
  input  logic                        invert_pol,
  input  logic                        reverse_bits,
  input  logic [WORD_W-1:0]           pattern,
  output logic [WORD_W-1:0]           aligned_word,
  output logic                        pat_found,
  output logic [$clog2(WORD_W)-1:0]   slip_count
);
  import rxwa_pkg::*;

  localparam int CNT_W = $clog2(WORD_W);
  localparam int WIN_W = 2 * WORD_W;

  wa_mode_e          mode;
  logic              slip_held, slip_evt;
  logic              en_held, en_rise;
  logic              srch_hit;
  logic [CNT_W-1:0]  hit_k;
  logic [CNT_W-1:0]  off_q;
  logic [WIN_W-1:0]  win;
  logic              rev_eff;

  assign mode    = wa_mode_e'(mode_manual);
  assign rev_eff = reverse_bits & (mode == WA_MODE_SLIP);

  rxwa_ctrl_sync #(.STAGES(2)) u_slip_sync (
    .clk(clk), .rst_n(rst_n), .async_in(slip_req),
    .held_lvl(slip_held), .rise(slip_evt)
  );

  rxwa_ctrl_sync #(.STAGES(2)) u_en_sync (
    .clk(clk), .rst_n(rst_n), .async_in(align_en),
    .held_lvl(en_held), .rise(en_rise)
  );

  rxwa_window #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .invert(invert_pol),
    .reverse(rev_eff), .pattern(pattern), .offset(off_q),
    .win_o(win), .aligned_o(aligned_word), .found_o(pat_found)
  );

  rxwa_search #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_srch (
    .clk(clk), .rst_n(rst_n), .active(mode == WA_MODE_HUNT),
    .en_lvl(en_held), .en_rise(en_rise), .win(win), .pattern(pattern),
    .hit(srch_hit), .hit_k(hit_k)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (mode == WA_MODE_HUNT) begin
      if (srch_hit) off_q <= hit_k;
    end else if (slip_evt) begin
      off_q <= CNT_W'(wa_wrap_inc(int'(off_q), WORD_W));
    end
  end

  assign slip_count = off_q;

  logic unused_held;
  assign unused_held = slip_held;
endmodule

// File: rtl/rxwa_chk.sv
module rxwa_chk #(
  parameter int WORD_W = 10,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_manual,
  input logic              slip_evt,
  input logic              srch_hit,
  input logic [CNT_W-1:0]  hit_k,
  input logic [CNT_W-1:0]  slip_count,
  input logic              pat_found,
  input logic              rev_eff,
  input logic [WORD_W-1:0] aligned_word,
  input logic [WORD_W-1:0] pattern
);
  AST_SLIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_manual && slip_evt) |=> slip_count ==
      (($past(slip_count) == CNT_W'(WORD_W - 1)) ? '0 : CNT_W'($past(slip_count) + 1'b1))); // R3
  AST_SLIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_manual && !slip_evt) |=> $stable(slip_count)); // R3
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slip_count) < WORD_W); // R4
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    slip_evt |=> !slip_evt); // R5
  AST_MANUAL_NO_SLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_manual && !srch_hit) |=> $stable(slip_count)); // R6
  AST_HIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_manual && srch_hit) |=> slip_count == $past(hit_k)); // R9
  AST_FOUND_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_found && !$past(rev_eff)) |-> aligned_word == $past(pattern)); // R12
endmodule

bind rx_word_aligner rxwa_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_manual(mode_manual), .slip_evt(slip_evt),
  .srch_hit(srch_hit), .hit_k(hit_k), .slip_count(slip_count),
  .pat_found(pat_found), .rev_eff(rev_eff), .aligned_word(aligned_word),
  .pattern(pattern)
);

// File: tb/sim_rx_word_aligner.sv
`timescale 1ns/1ps
module sim_rx_word_aligner;
  logic clk = 1'b0;
  logic rst_n, mode_manual, slip_req, align_en, invert_pol, reverse_bits;
  logic [9:0] rx10, pat10, al10;
  logic [7:0] rx8, pat8, al8;
  logic       f10, f8;
  logic [3:0] c10;
  logic [2:0] c8;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  bit periodic = 1'b0;
  int sh = 0, k10 = 0, k8 = 0;
  logic [9:0] prev10 = '0, prev8 = '0;

  always #5 clk = ~clk;

  rx_word_aligner #(.WORD_W(10)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_word(rx10), .mode_manual(mode_manual),
    .slip_req(slip_req), .align_en(align_en), .invert_pol(invert_pol),
    .reverse_bits(reverse_bits), .pattern(pat10), .aligned_word(al10),
    .pat_found(f10), .slip_count(c10));

  rx_word_aligner #(.WORD_W(8)) u1 (
    .clk(clk), .rst_n(rst_n), .rx_word(rx8), .mode_manual(mode_manual),
    .slip_req(slip_req), .align_en(align_en), .invert_pol(invert_pol),
    .reverse_bits(reverse_bits), .pattern(pat8), .aligned_word(al8),
    .pat_found(f8), .slip_count(c8));

  function automatic logic [9:0] msk(input int n);
    return 10'h3FF >> (10 - n);
  endfunction

  function automatic logic [9:0] rotl(input logic [9:0] v, input int s, input int n);
    logic [19:0] d;
    d = {10'b0, v & msk(n)} << s;
    d = d | (d >> n);
    return d[9:0] & msk(n);
  endfunction

  function automatic logic [9:0] slice_of(input logic [9:0] cur, input logic [9:0] prv,
                                          input int k, input int n);
    logic [19:0] h;
    h = ({10'b0, cur} << n) | {10'b0, prv};
    h = h >> k;
    return h[9:0] & msk(n);
  endfunction

  function automatic logic [9:0] rev_n(input logic [9:0] v, input int n);
    logic [9:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = v[n-1-i];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Apply one word to both copies; optionally check the registered result.
  task automatic cyc(input bit chk, input string tag);
    logic [9:0] r10, r8, e10, e8, s10, s8, x10, x8;
    if (periodic) begin
      r10 = rotl(pat10, sh, 10);
      r8  = rotl({2'b0, pat8}, sh, 8);
    end else begin
      r10 = 10'($urandom);
      r8  = 10'($urandom) & 10'h0FF;
    end
    rx10 = r10;
    rx8  = r8[7:0];
    e10 = r10 ^ (invert_pol ? 10'h3FF : 10'h000);       // R7
    e8  = r8  ^ (invert_pol ? 10'h0FF : 10'h000);
    s10 = slice_of(e10, prev10, k10, 10);
    s8  = slice_of(e8, prev8, k8, 8);
    x10 = (reverse_bits && !mode_manual) ? rev_n(s10, 10) : s10;
    x8  = (reverse_bits && !mode_manual) ? rev_n(s8, 8) : s8;
    @(posedge clk);
    @(negedge clk);
    prev10 = e10;
    prev8  = e8;
    if (chk) begin
      check(al10 === x10, {tag, " w10 word"}, al10, x10);
      check(al8 === x8[7:0], {tag, " w8 word"}, al8, x8);
      check(f10 === (s10 == pat10), "R12 w10 found", f10, (s10 == pat10));
      check(f8 === (s8[7:0] == pat8), "R12 w8 found", f8, (s8[7:0] == pat8));
    end
  endtask

  task automatic slip_pulse(input int len);
    slip_req = 1'b1;
    repeat (len) cyc(0, "");
    slip_req = 1'b0;
    repeat (6) cyc(0, "");
    if (len >= 2 && !mode_manual) begin
      k10 = (k10 + 1) % 10;
      k8  = (k8 + 1) % 8;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; mode_manual = 1'b0; slip_req = 1'b0; align_en = 1'b0;
    invert_pol = 1'b0; reverse_bits = 1'b0; rx10 = '0; rx8 = '0;
    pat10 = 10'h0FA; pat8 = 8'h1D;
    repeat (4) @(negedge clk);
    check(al10 === 10'h0 && al8 === 8'h0, "R1 words", {al10, al8}, 0);
    check(c10 === 4'h0 && c8 === 3'h0, "R1 count", {c10, c8}, 0);
    check(f10 === 1'b0 && f8 === 1'b0, "R1 found", {f10, f8}, 0);
    rst_n = 1'b1;

    repeat (40) cyc(1, "R2");
    invert_pol = 1'b1;
    repeat (30) cyc(1, "R7");
    invert_pol = 1'b0;

    // Twelve accepted slips: the 10-bit copy wraps once (R4), the 8-bit one too.
    for (int i = 0; i < 12; i++) begin
      slip_pulse(2 + (i % 2));
      repeat (6) cyc(1, "R3");
      check(c10 === 4'(k10), (k10 == 0) ? "R4 w10 wrap" : "R3 w10 count", c10, k10);
      check(c8 === 3'(k8), (k8 == 0) ? "R4 w8 wrap" : "R3 w8 count", c8, k8);
    end

    // Single-cycle pulses are rejected.
    for (int i = 0; i < 3; i++) begin
      slip_pulse(1);
      repeat (3) cyc(1, "R5");
      check(c10 === 4'(k10), "R5 w10 short pulse", c10, k10);
      check(c8 === 3'(k8), "R5 w8 short pulse", c8, k8);
    end

    reverse_bits = 1'b1;
    repeat (30) cyc(1, "R8");
    // Random mix of polarity and reversal.
    for (int i = 0; i < 12; i++) begin
      invert_pol   = 1'($urandom);
      reverse_bits = 1'($urandom);
      repeat (5) cyc(1, "R2");
    end
    invert_pol = 1'b0;

    // Manual mode: slips ignored, reversal ignored.
    reverse_bits = 1'b1;
    mode_manual  = 1'b1;
    slip_pulse(3);
    check(c10 === 4'(k10), "R6 w10 slip ignored", c10, k10);
    check(c8 === 3'(k8), "R6 w8 slip ignored", c8, k8);
    repeat (10) cyc(1, "R8");

    // Search on a periodic stream shifted by 3.
    periodic = 1'b1; sh = 3;
    repeat (5) cyc(0, "");
    align_en = 1'b1;
    repeat (12) cyc(0, "");
    check(c10 === 4'd3, "R9 w10 lock", c10, 3);
    check(c8 === 3'd3, "R9 w8 lock", c8, 3);
    check(al10 === pat10 && f10 === 1'b1, "R12 w10 aligned", {f10, al10}, {1'b1, pat10});
    check(al8 === pat8 && f8 === 1'b1, "R12 w8 aligned", {f8, al8}, {1'b1, pat8});

    // Stream shifts while enable stays high.
    sh = 7;
    repeat (12) cyc(0, "");
    check(c10 === 4'd7, "R11 w10 follows", c10, 7);
    check(c8 === 3'd3, "R10 w8 single search", c8, 3);

    // Enable low: both hold.
    align_en = 1'b0;
    repeat (6) cyc(0, "");
    sh = 5;
    repeat (12) cyc(0, "");
    check(c10 === 4'd7, "R11 w10 holds", c10, 7);
    check(c8 === 3'd3, "R10 w8 holds", c8, 3);
    check(f10 === 1'b0, "R12 w10 off boundary", f10, 0);

    // New rising edge re-arms the 8-bit search.
    align_en = 1'b1;
    repeat (12) cyc(0, "");
    check(c10 === 4'd5, "R11 w10 relock", c10, 5);
    check(c8 === 3'd5, "R10 w8 rearm", c8, 5);

    // Several offsets match: the lowest is chosen.
    align_en = 1'b0;
    repeat (6) cyc(0, "");
    pat10 = 10'h155; pat8 = 8'h55; sh = 1;
    repeat (6) cyc(0, "");
    align_en = 1'b1;
    repeat (12) cyc(0, "");
    check(c10 === 4'd1, "R9 w10 lowest", c10, 1);
    check(c8 === 3'd1, "R9 w8 lowest", c8, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule